// File: doc/BRIEF.md
# Upstream Attach Pull-up Sequencer

This block decides when the upstream data-line pull-up may be driven, so that the device signals attachment only after a settling time. The pull-up is released (high impedance) after a system reset and whenever the power-source indicator changes level. It is driven high again only after a full settling window of core clock cycles.

The tri-state pad is formed from two outputs: a drive value and a drive enable. The power-source indicator is asynchronous to the core clock. It is synchronized, and then each level change is detected exactly once. A change that arrives while the window is still running reloads the counter from zero. A one-cycle status pulse marks the moment the pull-up becomes driven.

Top module: `attach_pullup_seq`

## Requirements
- R1: While `rst_n` is low, `pullup_oe_o` is 0. After `rst_n` rises, `pullup_oe_o` stays 0 through the first DELAY_CYCLES-1 rising clock edges and becomes 1 at rising edge number DELAY_CYCLES.
- R2: Once `pullup_oe_o` is 1, `pullup_o` is 1. Both hold until the next restart event, which is a system reset or a power-source change.
- R3: A level change on `pwr_src_i`, rising or falling, is a restart event. `pullup_oe_o` drops to 0 at the third rising edge after the change: two synchronizer stages plus detection. It rises again DELAY_CYCLES edges after that third edge.
- R4: A power-source change that occurs while the window is running reloads the count to zero. The pull-up becomes driven DELAY_CYCLES edges after the latest change is detected, not earlier.
- R5: `attached_o` is high for exactly one cycle, in the same cycle that `pullup_oe_o` goes from 0 to 1. It stays low at all other times.
- R6: The level that `pwr_src_i` has when reset is released is not treated as a change, whether it is 0 or 1.
- R7: The window length is the parameter DELAY_CYCLES, counted in core clock cycles, with a default of 720000 (15 ms at 48 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| pwr_src_i | input | 1 | Power-source indicator, asynchronous; any level change restarts the window |
| pullup_o | output | 1 | Value driven onto the pull-up pad (1 when driven) |
| pullup_oe_o | output | 1 | Pad drive enable; 0 means high impedance |
| attached_o | output | 1 | One-cycle pulse when the pull-up first becomes driven |

## Verification
After reset is released, the drive enable is due at exactly edge DELAY_CYCLES. After a power-source change it is due to drop at the third edge and to rise DELAY_CYCLES edges later. The bench uses a small window length and drives every input at a falling edge. It then counts rising edges explicitly before sampling at the next falling edge, so it checks both the last cycle before each transition and the transition cycle itself. The status pulse is sampled in the rise cycle and in the cycle after it.

// File: rtl/attach_seq_pkg.sv
package attach_seq_pkg;

  // Counter width needed to hold values 0 .. n-1 (at least one bit).
  function automatic int cnt_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // True when the count has reached the final cycle of the window.
  function automatic logic window_done(input int unsigned cnt, input int unsigned len);
    return cnt == (len - 1);
  endfunction

endpackage

// File: rtl/aps_sync.sv
module aps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[i] <= 1'b0;
      else        chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/aps_change_det.sv
module aps_change_det #(
  parameter int FILL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic change
);
  localparam int FW = $clog2(FILL + 1);

  logic [FW-1:0] fill_q;
  logic          prev_q;
  logic          primed;

  assign primed = (fill_q == FW'(FILL));
  assign change = primed && (level != prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= level;
      if (!primed) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/aps_settle_timer.sv
module aps_settle_timer
  import attach_seq_pkg::*;
#(
  parameter int DELAY = 720000,
  parameter int CW    = cnt_bits(DELAY)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic          drive,
  output logic          expire_pulse,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q;
  logic          drive_q;
  logic          pulse_q;
  logic          expiry;

  assign expiry = !drive_q && !restart && window_done(32'(cnt_q), DELAY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      drive_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= expiry;
      if (restart) begin
        cnt_q   <= '0;
        drive_q <= 1'b0;
      end else if (expiry) begin
        drive_q <= 1'b1;
      end else if (!drive_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign drive        = drive_q;
  assign expire_pulse = pulse_q;
  assign count        = cnt_q;
endmodule

// File: rtl/attach_pullup_seq.sv
module attach_pullup_seq
  import attach_seq_pkg::*;
#(
  parameter int DELAY_CYCLES = 720000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_src_i,
  output logic pullup_o,
  output logic pullup_oe_o,
  output logic attached_o
);
  localparam int CNT_W = cnt_bits(DELAY_CYCLES);

  logic             pwr_sync_w;
  logic             restart_w;
  logic             drive_w;
  logic             expire_w;
  logic [CNT_W-1:0] count_w;

  aps_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pwr_src_i), .q(pwr_sync_w)
  );

  aps_change_det #(.FILL(SYNC_STAGES + 1)) det_i (
    .clk(clk), .rst_n(rst_n), .level(pwr_sync_w), .change(restart_w)
  );

  aps_settle_timer #(.DELAY(DELAY_CYCLES), .CW(CNT_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .restart(restart_w),
    .drive(drive_w), .expire_pulse(expire_w), .count(count_w)
  );

  assign pullup_o    = drive_w;
  assign pullup_oe_o = drive_w;
  assign attached_o  = expire_w;
endmodule

// File: rtl/aps_checker.sv
module aps_checker #(
  parameter int CW = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pullup_o,
  input logic          pullup_oe_o,
  input logic          attached_o,
  input logic          restart_w,
  input logic [CW-1:0] count_w
);
  always @(posedge clk) begin
    if (!rst_n) AST_HIZ_IN_RESET: assert (!pullup_oe_o && !attached_o); // R1
  end

  AST_DRIVEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_oe_o |-> pullup_o); // R2

  AST_HOLD_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pullup_oe_o && !restart_w) |=> pullup_oe_o); // R2

  AST_RESTART_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_w |=> !pullup_oe_o); // R3

  AST_RESTART_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    restart_w |=> (count_w == '0)); // R4

  AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pullup_oe_o) |-> attached_o); // R5

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    attached_o |=> !attached_o); // R5

  AST_PULSE_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    attached_o |-> pullup_oe_o); // R5
endmodule

bind attach_pullup_seq aps_checker #(.CW(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pullup_o(pullup_o), .pullup_oe_o(pullup_oe_o),
  .attached_o(attached_o), .restart_w(restart_w), .count_w(count_w)
);

// File: tb/attach_pullup_seq_tb_top.sv
`timescale 1ns/1ps
module attach_pullup_seq_tb_top;
  localparam int DLY = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr = 1'b0;
  logic pu, oe, att;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  attach_pullup_seq #(.DELAY_CYCLES(DLY), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_src_i(pwr),
    .pullup_o(pu), .pullup_oe_o(oe), .attached_o(att)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // n rising edges, then settle at the falling edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic lvl);
    @(negedge clk);
    rst_n = 1'b0;
    pwr = lvl;
    #1;
    check(oe, 1'b0, "R1 oe low in reset");
    check(att, 1'b0, "R5 no pulse in reset");
    step(3);
    rst_n = 1'b1;
  endtask

  // After release at a negedge: verify window of DLY edges (R1, R6, R7)
  task automatic t_reset_window(input logic lvl);
    do_reset(lvl);
    step(DLY - 1);
    check(oe, 1'b0, "R1/R6 oe low at edge DELAY-1");
    step(1);
    check(oe, 1'b1, "R1/R7 oe high at edge DELAY");
    check(pu, 1'b1, "R2 value high when driven");
    check(att, 1'b1, "R5 pulse with rise");
    step(1);
    check(att, 1'b0, "R5 pulse one cycle");
    step(3 * DLY);
    check(oe, 1'b1, "R2 stays driven");
    check(att, 1'b0, "R5 no repeat pulse");
  endtask

  // Toggle power source while driven (R3)
  task automatic t_toggle(input logic lvl);
    pwr = lvl;
    step(2);
    check(oe, 1'b1, "R3 still driven at edge 2");
    step(1);
    check(oe, 1'b0, "R3 released at edge 3");
    step(DLY - 1);
    check(oe, 1'b0, "R3 low before window end");
    check(att, 1'b0, "R5 no early pulse");
    step(1);
    check(oe, 1'b1, "R3 redriven after window");
    check(att, 1'b1, "R5 pulse after restart");
    step(1);
    check(att, 1'b0, "R5 pulse one cycle");
  endtask

  // Second change mid-window reloads the count (R4)
  task automatic t_reload;
    pwr = ~pwr;
    step(3);
    check(oe, 1'b0, "R4 released");
    step(20);
    pwr = ~pwr;
    step(3);
    step(DLY - 4);
    check(oe, 1'b0, "R4 not driven at old expiry");
    step(3);
    check(oe, 1'b0, "R4 low at new edge DELAY-1");
    step(1);
    check(oe, 1'b1, "R4 driven DELAY after latest change");
  endtask

  // Reset while driven releases immediately (R1)
  task automatic t_reset_while_driven;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(oe, 1'b0, "R1 async release on reset");
    step(2);
    rst_n = 1'b1;
    step(DLY);
    check(oe, 1'b1, "R1 driven again after window");
  endtask

  initial begin
    fork
      begin
        t_reset_window(1'b0);
        t_toggle(1'b1);
        t_toggle(1'b0);
        t_reload();
        t_reset_window(1'b1);
        t_toggle(1'b0);
        t_reset_while_driven();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule